// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR flash. It takes word-program, sector-erase and chip-erase requests on a valid/ready interface. It expands each request into the flash's unlock-and-command write sequence and produces chip-enable, write-enable and output-enable strobes with registered timing. It then watches for the end of the embedded operation by reading bit 7 of the flash data bus again and again. Each request ends with a one-cycle done pulse that carries an error flag.

A program request first reads the target word. If the new value needs any bit to go from 0 to 1, the request fails before any write is issued, because only an erase can set bits. When the block has no request in progress, host reads pass straight through to the flash bus.

States: `ST_IDLE` (ready; read passthrough) goes to `ST_CHECK` on a program request, to `ST_CMD` on an erase request, and to `ST_RESP` on a reserved opcode. `ST_CHECK` (pre-read of the target word) goes to `ST_RESP` with an error on a 0-to-1 conflict, and otherwise to `ST_CMD`. `ST_CMD` (command writes) goes to `ST_POLL` after its last write. `ST_POLL` (status reads) goes to `ST_RESP` when the completion bit matches or the timeout has expired. `ST_RESP` (done pulse) always returns to `ST_IDLE`.

Top module: `flash_op_seq`

## Requirements
- R1: `req_ready` is high only in idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance through the done pulse, and high again in the cycle after it.
- R2: A program (`req_op`=0) issues exactly four writes as (address, data): (5555h, 00AAh), (2AAAh, 0055h), (5555h, 00A0h), then (target address, target data).
- R3: A sector erase (`req_op`=1) issues exactly six writes: (5555h,AAh), (2AAAh,55h), (5555h,80h), (5555h,AAh), (2AAAh,55h), and a sixth write of (request address, 30h). A chip erase (`req_op`=2) issues the same first five writes, then (5555h, 10h).
- R4: In every write cycle, address and write data are stable for at least one clock before `fl_we_n`/`fl_ce_n` fall. The strobe stays low for exactly STRB_CLKS clocks. The address is still held in the clock after the strobe rises. `fl_oe_n` stays high and `fl_dq_oe` stays high throughout the write.
- R5: A program completes without error once a read of the target address returns bit 7 equal to bit 7 of the programmed data.
- R6: An erase completes without error once a status read returns bit 7 equal to 1.
- R7: The first status read starts right after the final write. Between the strobe rising on the final write and `fl_oe_n` falling there are exactly two clocks (the hold clock and one setup clock).
- R8: Before a program, the target word is read. If the data has a 1 in any bit where the word holds 0, the request ends with `rsp_err`=1 and no write cycles. A program that only clears bits proceeds normally.
- R9: If completion is not seen within POLL_LIMIT clocks of polling, the request ends with `rsp_err`=1 and the block returns to idle.
- R10: In idle, `fl_addr` follows `rd_addr`, `fl_ce_n` and `fl_oe_n` are the inverse of `rd_en`, `fl_we_n` is high, and `rd_data` shows `fl_dq_i`.
- R11: `rsp_done` is a one-cycle pulse. `rsp_err` is only high together with it.
- R12: The reserved opcode (`req_op`=3) ends with `rsp_err`=1 and no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Program data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid with rsp_done |
| rd_en | input | 1 | Passthrough read enable (idle only) |
| rd_addr | input | AW | Passthrough read address |
| rd_data | output | DW | Passthrough read data |
| fl_addr | output | AW | Flash address bus |
| fl_dq_o | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for flash data bus |
| fl_dq_i | input | DW | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The sequencer is driven with every opcode against a behavioural flash model that decodes the unlock sequences and returns complemented or zero bit 7 while busy. Programs use data with bit 7 both clear and set, which shows that completion is compared against the programmed data and not a fixed level. Programs over an erased word, over a word whose bits they only clear, and over a word they would need to set separate the pre-read rejection from a normal program. Sector and chip erase are told apart by which words read back as all ones afterwards, and a model that never finishes exercises the timeout path.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } flash_op_e;

    typedef enum logic [1:0] {
        AS_UNLK_A,
        AS_UNLK_B,
        AS_TARGET
    } addr_sel_e;

    localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;

    localparam logic [7:0] CODE_KEY1  = 8'hAA;
    localparam logic [7:0] CODE_KEY2  = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_CHIP  = 8'h10;

    typedef struct packed {
        addr_sel_e  asel;
        logic       tgt_data;
        logic [7:0] code;
    } cmd_word_t;

    function automatic logic [2:0] write_count(flash_op_e op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_seq_pkg::*;
(
    input  flash_op_e  op,
    input  logic [2:0] step,
    output cmd_word_t  word
);
    always_comb begin
        word = '{asel: AS_UNLK_A, tgt_data: 1'b0, code: CODE_KEY1};
        case (step)
            3'd0: word = '{asel: AS_UNLK_A, tgt_data: 1'b0, code: CODE_KEY1};
            3'd1: word = '{asel: AS_UNLK_B, tgt_data: 1'b0, code: CODE_KEY2};
            3'd2: word = '{asel: AS_UNLK_A, tgt_data: 1'b0,
                           code: (op == OP_PROG) ? CODE_PROG : CODE_ERASE};
            3'd3: begin
                if (op == OP_PROG)
                    word = '{asel: AS_TARGET, tgt_data: 1'b1, code: 8'h00};
                else
                    word = '{asel: AS_UNLK_A, tgt_data: 1'b0, code: CODE_KEY1};
            end
            3'd4: word = '{asel: AS_UNLK_B, tgt_data: 1'b0, code: CODE_KEY2};
            3'd5: begin
                if (op == OP_CHIP)
                    word = '{asel: AS_UNLK_A, tgt_data: 1'b0, code: CODE_CHIP};
                else
                    word = '{asel: AS_TARGET, tgt_data: 1'b0, code: CODE_SECT};
            end
            default: word = '{asel: AS_UNLK_A, tgt_data: 1'b0, code: CODE_KEY1};
        endcase
    end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
    parameter int AW        = 19,
    parameter int DW        = 16,
    parameter int STRB_CLKS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] rdata_i,
    output logic          ce_n_o,
    output logic          we_n_o,
    output logic          oe_n_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          drive_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o
);
    localparam int CW = $clog2(STRB_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(STRB_CLKS - 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STRB, PH_HOLD} phase_e;

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          accept;

    assign accept = start_i && (phase_q == PH_IDLE || phase_q == PH_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            phase_q <= PH_SETUP;
            cnt_q   <= '0;
            wr_q    <= wr_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end else begin
            unique case (phase_q)
                PH_IDLE:  phase_q <= PH_IDLE;
                PH_SETUP: begin
                    phase_q <= PH_STRB;
                    cnt_q   <= '0;
                end
                PH_STRB: begin
                    if (cnt_q == LAST) begin
                        phase_q <= PH_HOLD;
                        if (!wr_q) rdata_q <= rdata_i;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HOLD:  phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ce_n_o  = !(phase_q == PH_STRB);
        we_n_o  = !(phase_q == PH_STRB && wr_q);
        oe_n_o  = !(phase_q == PH_STRB && !wr_q);
        drive_o = wr_q && (phase_q != PH_IDLE);
        addr_o  = addr_q;
        wdata_o = wdata_q;
        rdata_o = rdata_q;
        done_o  = (phase_q == PH_HOLD);
    end

    // R4
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n_o) |-> ($stable(addr_o) && $stable(wdata_o)));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> $stable(addr_o));

    // R4
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_o && !oe_n_o));

    // R4
    strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STRB && cnt_q == LAST && !accept) |=> (ce_n_o && done_o));
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] TOP = TW'(LIMIT);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (clear_i)                cnt_q <= '0;
        else if (run_i && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == TOP);
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 16,
    parameter int STRB_CLKS  = 3,
    parameter int POLL_LIMIT = 100000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          rsp_done,
    output logic          rsp_err,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_i,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_CMD, ST_POLL, ST_RESP} state_e;

    state_e        state_q, state_d;
    flash_op_e     op_q, op_cur;
    logic [AW-1:0] addr_q, tgt_addr, cmd_addr;
    logic [DW-1:0] data_q, tgt_data, cmd_data;
    logic [2:0]    step_q, step_d;
    logic          err_q, err_d;
    cmd_word_t     cmd;

    logic          bus_start, bus_wr, bus_done;
    logic [AW-1:0] bus_addr, bus_addr_o;
    logic [DW-1:0] bus_wdata, bus_wdata_o, bus_rdata;
    logic          bus_ce_n, bus_we_n, bus_oe_n, bus_drive;
    logic          tmr_clear, tmr_expired;
    logic          poll_hit, zero_to_one, accept;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign op_cur   = flash_op_e'((state_q == ST_IDLE) ? req_op : op_q);
    assign tgt_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
    assign tgt_data = (state_q == ST_IDLE) ? req_data : data_q;

    flash_cmd_rom u_rom (
        .op   (op_cur),
        .step (step_q),
        .word (cmd)
    );

    always_comb begin
        unique case (cmd.asel)
            AS_UNLK_A: cmd_addr = AW'(UNLK_ADDR_A);
            AS_UNLK_B: cmd_addr = AW'(UNLK_ADDR_B);
            default:   cmd_addr = tgt_addr;
        endcase
        cmd_data = cmd.tgt_data ? tgt_data : DW'(cmd.code);
    end

    assign poll_hit    = (op_q == OP_PROG) ? (bus_rdata[7] == data_q[7]) : bus_rdata[7];
    assign zero_to_one = |(data_q & ~bus_rdata);

    flash_bus_cycle #(.AW(AW), .DW(DW), .STRB_CLKS(STRB_CLKS)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (bus_start),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_i (fl_dq_i),
        .ce_n_o  (bus_ce_n),
        .we_n_o  (bus_we_n),
        .oe_n_o  (bus_oe_n),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o),
        .drive_o (bus_drive),
        .rdata_o (bus_rdata),
        .done_o  (bus_done)
    );

    flash_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmr_clear),
        .run_i     (state_q == ST_POLL),
        .expired_o (tmr_expired)
    );

    // next-state and control
    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        err_d     = err_q;
        bus_start = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = tgt_addr;
        bus_wdata = tgt_data;
        tmr_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                step_d = '0;
                if (req_valid) begin
                    err_d = 1'b0;
                    case (op_cur)
                        OP_RSVD: begin
                            err_d   = 1'b1;
                            state_d = ST_RESP;
                        end
                        OP_PROG: begin
                            bus_start = 1'b1;
                            state_d   = ST_CHECK;
                        end
                        default: begin
                            bus_start = 1'b1;
                            bus_wr    = 1'b1;
                            bus_addr  = cmd_addr;
                            bus_wdata = cmd_data;
                            step_d    = 3'd1;
                            state_d   = ST_CMD;
                        end
                    endcase
                end
            end
            ST_CHECK: begin
                if (bus_done) begin
                    if (zero_to_one) begin
                        err_d   = 1'b1;
                        state_d = ST_RESP;
                    end else begin
                        bus_start = 1'b1;
                        bus_wr    = 1'b1;
                        bus_addr  = cmd_addr;
                        bus_wdata = cmd_data;
                        step_d    = 3'd1;
                        state_d   = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                if (bus_done) begin
                    if (step_q == write_count(op_q)) begin
                        bus_start = 1'b1;
                        tmr_clear = 1'b1;
                        step_d    = '0;
                        state_d   = ST_POLL;
                    end else begin
                        bus_start = 1'b1;
                        bus_wr    = 1'b1;
                        bus_addr  = cmd_addr;
                        bus_wdata = cmd_data;
                        step_d    = step_q + 3'd1;
                    end
                end
            end
            ST_POLL: begin
                if (bus_done) begin
                    if (poll_hit) begin
                        state_d = ST_RESP;
                    end else if (tmr_expired) begin
                        err_d   = 1'b1;
                        state_d = ST_RESP;
                    end else begin
                        bus_start = 1'b1;
                    end
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            err_q   <= 1'b0;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            err_q   <= err_d;
            if (accept) begin
                op_q   <= flash_op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_RESP);
        rsp_err   = (state_q == ST_RESP) && err_q;
        rd_data   = fl_dq_i;
        if (state_q == ST_IDLE) begin
            fl_addr  = rd_addr;
            fl_dq_o  = '0;
            fl_dq_oe = 1'b0;
            fl_ce_n  = !rd_en;
            fl_oe_n  = !rd_en;
            fl_we_n  = 1'b1;
        end else begin
            fl_addr  = bus_addr_o;
            fl_dq_o  = bus_wdata_o;
            fl_dq_oe = bus_drive;
            fl_ce_n  = bus_ce_n;
            fl_oe_n  = bus_oe_n;
            fl_we_n  = bus_we_n;
        end
    end

    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> req_ready);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9
    poll_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && bus_done && !poll_hit && tmr_expired) |=> (rsp_done && rsp_err));

    // R7
    poll_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && bus_done && step_q == write_count(op_q)) |=> (state_q == ST_POLL && fl_ce_n));
endmodule

// File: tb/flash_op_seq_bench.sv
module flash_op_seq_bench;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int STRB = 3;
    localparam int LIMIT = 300;
    localparam int PROG_T = 40;
    localparam int ERASE_T = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic rsp_done, rsp_err;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_o, fl_dq_i;
    logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_op_seq #(.AW(AW), .DW(DW), .STRB_CLKS(STRB), .POLL_LIMIT(LIMIT)) u_flash_op_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data),
        .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash model and bus monitor ----------------
    logic [15:0] mem [256];
    int  cmd_ph = 0;
    int  busy = 0;
    int  kind = 0;
    logic [15:0] pend_data = '0;
    logic [7:0]  pend_idx = '0;
    bit  stuck = 0;
    bit  model_clear = 0;

    logic [15:0] wa [256];
    logic [15:0] wd [256];
    int  wn = 0;
    logic prev_we = 1'b1;
    logic [15:0] prev_addr = '0, prev_dq = '0, strb_addr = '0;
    int  lowlen = 0;
    bit  gap_arm = 0;
    int  gap = 0;
    int  last_gap = -1;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0]};
    end

    always_comb begin
        if (busy > 0 && kind == 0)
            fl_dq_i = {mem[fl_addr[7:0]][15:8], ~pend_data[7], mem[fl_addr[7:0]][6:0]};
        else if (busy > 0)
            fl_dq_i = {mem[fl_addr[7:0]][15:8], 1'b0, mem[fl_addr[7:0]][6:0]};
        else
            fl_dq_i = mem[fl_addr[7:0]];
    end

    always @(negedge clk) begin
        if (model_clear) begin
            busy = 0;
            cmd_ph = 0;
        end
        if (rst_n) begin
            if (!fl_we_n) lowlen++;
            if (prev_we && !fl_we_n && !fl_ce_n) begin
                // R4 setup and bus direction at strobe fall
                chk(fl_addr == prev_addr && fl_dq_o == prev_dq, "R4 setup", fl_addr, prev_addr);
                chk(fl_oe_n && fl_dq_oe, "R4 oe/drive", {fl_oe_n, fl_dq_oe}, 2'b11);
                if (wn < 256) begin
                    wa[wn] = fl_addr;
                    wd[wn] = fl_dq_o;
                end
                wn++;
                if (busy == 0) begin
                    case (cmd_ph)
                        0: cmd_ph = (fl_addr == 16'h5555 && fl_dq_o[7:0] == 8'hAA) ? 1 : 0;
                        1: cmd_ph = (fl_addr == 16'h2AAA && fl_dq_o[7:0] == 8'h55) ? 2 : 0;
                        2: cmd_ph = (fl_addr == 16'h5555 && fl_dq_o[7:0] == 8'hA0) ? 10 :
                                    (fl_addr == 16'h5555 && fl_dq_o[7:0] == 8'h80) ? 3 : 0;
                        3: cmd_ph = (fl_addr == 16'h5555 && fl_dq_o[7:0] == 8'hAA) ? 4 : 0;
                        4: cmd_ph = (fl_addr == 16'h2AAA && fl_dq_o[7:0] == 8'h55) ? 5 : 0;
                        5: begin
                            if (fl_dq_o[7:0] == 8'h30) begin
                                kind = 1; pend_idx = fl_addr[7:0]; busy = ERASE_T;
                            end else if (fl_addr == 16'h5555 && fl_dq_o[7:0] == 8'h10) begin
                                kind = 2; busy = ERASE_T;
                            end
                            cmd_ph = 0;
                        end
                        10: begin
                            kind = 0; pend_idx = fl_addr[7:0]; pend_data = fl_dq_o;
                            busy = PROG_T; cmd_ph = 0;
                        end
                        default: cmd_ph = 0;
                    endcase
                end
            end
            if (!prev_we && fl_we_n) begin
                // R4 strobe width and address hold
                chk(lowlen == STRB, "R4 width", lowlen, STRB);
                chk(fl_addr == strb_addr, "R4 hold", fl_addr, strb_addr);
                lowlen = 0;
                gap_arm = 1;
                gap = 1;
            end else if (gap_arm) begin
                if (!fl_oe_n) begin
                    last_gap = gap;
                    gap_arm = 0;
                end else gap++;
            end
            if (!fl_we_n) strb_addr = fl_addr;
            if (busy > 0 && !stuck) begin
                busy--;
                if (busy == 0) begin
                    if (kind == 0) mem[pend_idx] = mem[pend_idx] & pend_data;
                    else if (kind == 1) begin
                        for (int i = 0; i < 256; i++)
                            if (i[7:6] == pend_idx[7:6]) mem[i] = 16'hFFFF;
                    end else begin
                        for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
                    end
                end
            end
            prev_we = fl_we_n;
            prev_addr = fl_addr;
            prev_dq = fl_dq_o;
        end
    end

    // ---------------- helpers ----------------
    task automatic do_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                         output logic err, output int wcount, output int cycles);
        int ws;
        int n;
        @(negedge clk);
        ws = wn;
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 ready low after accept", req_ready, 0);
        n = 0;
        while (!rsp_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, "R11 done seen", n, 0);
        err = rsp_err;
        cycles = n;
        wcount = wn - ws;
        @(negedge clk);
        chk(req_ready && !rsp_done && !rsp_err, "R11/R1 one-cycle done then ready",
            {req_ready, rsp_done, rsp_err}, 3'b100);
    endtask

    task automatic rd_word(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1;
        v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_write(input int idx, input logic [15:0] ea, input logic [15:0] ed, input string tag);
        chk(wa[idx] == ea && wd[idx] == ed, tag, {wa[idx], wd[idx]}, {ea, ed});
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(!rsp_done && !rsp_err, "R11 no done after reset", {rsp_done, rsp_err}, 0);
        chk(fl_we_n && fl_ce_n && fl_oe_n, "R10 bus quiet", {fl_we_n, fl_ce_n, fl_oe_n}, 3'b111);
    endtask

    task automatic t_passthru();
        logic [15:0] v;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 16'h0012;
        #1;
        chk(!fl_ce_n && !fl_oe_n && fl_we_n && fl_addr == 16'h0012, "R10 strobes",
            {fl_ce_n, fl_oe_n, fl_we_n}, 3'b001);
        chk(rd_data == 16'h12ED, "R10 data", rd_data, 16'h12ED);
        @(negedge clk);
        rd_en = 1'b0;
        rd_word(16'h00F0, v);
        chk(v == 16'hF00F, "R10 data second", v, 16'hF00F);
    endtask

    task automatic t_conflict();
        logic e; int w, c; logic [15:0] v;
        do_op(2'd0, 16'h0012, 16'hFFFF, e, w, c);
        chk(e == 1'b1, "R8 conflict error", e, 1);
        chk(w == 0, "R8 no writes", w, 0);
        rd_word(16'h0012, v);
        chk(v == 16'h12ED, "R8 word unchanged", v, 16'h12ED);
    endtask

    task automatic t_bad_op();
        logic e; int w, c;
        do_op(2'd3, 16'h0020, 16'h0000, e, w, c);
        chk(e == 1'b1, "R12 reserved error", e, 1);
        chk(w == 0, "R12 no writes", w, 0);
    endtask

    task automatic t_chip_erase();
        logic e; int w, c, b; logic [15:0] v;
        b = wn;
        do_op(2'd2, 16'h0000, 16'h0000, e, w, c);
        chk(e == 1'b0, "R6 chip erase ok", e, 0);
        chk(w == 6, "R3 chip erase six writes", w, 6);
        chk_write(b + 0, 16'h5555, 16'h00AA, "R3 chip w1");
        chk_write(b + 1, 16'h2AAA, 16'h0055, "R3 chip w2");
        chk_write(b + 2, 16'h5555, 16'h0080, "R3 chip w3");
        chk_write(b + 3, 16'h5555, 16'h00AA, "R3 chip w4");
        chk_write(b + 4, 16'h2AAA, 16'h0055, "R3 chip w5");
        chk_write(b + 5, 16'h5555, 16'h0010, "R3 chip w6");
        chk(c > ERASE_T, "R6 waited for erase", c, ERASE_T);
        rd_word(16'h0012, v);
        chk(v == 16'hFFFF, "R6 erased 12", v, 16'hFFFF);
        rd_word(16'h00F0, v);
        chk(v == 16'hFFFF, "R6 erased F0", v, 16'hFFFF);
    endtask

    task automatic t_program();
        logic e; int w, c, b; logic [15:0] v;
        b = wn;
        do_op(2'd0, 16'h0034, 16'h1234, e, w, c);
        chk(e == 1'b0, "R5 program ok bit7=0", e, 0);
        chk(w == 4, "R2 four writes", w, 4);
        chk_write(b + 0, 16'h5555, 16'h00AA, "R2 w1");
        chk_write(b + 1, 16'h2AAA, 16'h0055, "R2 w2");
        chk_write(b + 2, 16'h5555, 16'h00A0, "R2 w3");
        chk_write(b + 3, 16'h0034, 16'h1234, "R2 w4");
        chk(last_gap == 2, "R7 poll starts at once", last_gap, 2);
        chk(c > PROG_T, "R5 waited for program", c, PROG_T);
        rd_word(16'h0034, v);
        chk(v == 16'h1234, "R5 readback", v, 16'h1234);
        do_op(2'd0, 16'h0035, 16'h00A5, e, w, c);
        chk(e == 1'b0 && c > PROG_T, "R5 program ok bit7=1", c, PROG_T);
        rd_word(16'h0035, v);
        chk(v == 16'h00A5, "R5 readback bit7=1", v, 16'h00A5);
        do_op(2'd0, 16'h0034, 16'h1230, e, w, c);
        chk(e == 1'b0 && w == 4, "R8 clear-only program allowed", {e, w[3:0]}, 5'h04);
        rd_word(16'h0034, v);
        chk(v == 16'h1230, "R8 clear-only readback", v, 16'h1230);
    endtask

    task automatic t_sector();
        logic e; int w, c, b; logic [15:0] v;
        do_op(2'd0, 16'h0045, 16'h0F0F, e, w, c);
        chk(e == 1'b0, "R5 program in sector 1", e, 0);
        b = wn;
        do_op(2'd1, 16'h0040, 16'h0000, e, w, c);
        chk(e == 1'b0, "R6 sector erase ok", e, 0);
        chk(w == 6, "R3 sector six writes", w, 6);
        chk_write(b + 2, 16'h5555, 16'h0080, "R3 sector w3");
        chk_write(b + 5, 16'h0040, 16'h0030, "R3 sector w6");
        chk(last_gap == 2, "R7 erase poll starts at once", last_gap, 2);
        rd_word(16'h0045, v);
        chk(v == 16'hFFFF, "R6 sector erased", v, 16'hFFFF);
        rd_word(16'h0034, v);
        chk(v == 16'h1230, "R3 other sector kept", v, 16'h1230);
    endtask

    task automatic t_timeout();
        logic e; int w, c;
        stuck = 1;
        do_op(2'd0, 16'h0080, 16'h5555, e, w, c);
        chk(e == 1'b1, "R9 timeout error", e, 1);
        chk(c >= LIMIT, "R9 waited for limit", c, LIMIT);
        stuck = 0;
        model_clear = 1;
        @(negedge clk);
        model_clear = 0;
        chk(req_ready == 1'b1, "R9 back to idle", req_ready, 1);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthru();
        t_conflict();
        t_bad_op();
        t_chip_erase();
        t_program();
        t_sector();
        t_timeout();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule